// File: doc/BRIEF.md
# I2C Slave Bus Engine

This block is the bus side of a register-mapped I2C slave peripheral. It watches the SCL and SDA lines, which are oversampled by the system clock, and recognises START, repeated START and STOP. It collects the address byte and compares it with a programmed 7-bit own address, with the general-call address, or with a 10-bit address that arrives as a header byte followed by a second byte. Once the block is selected, it receives bytes from the master or sends bytes to it. It pulls SDA low through an open-drain output enable to acknowledge and to send zero bits.

The engine reports single-cycle raw events to a separate status block: address matched, byte done, acknowledge failure and STOP. After every data byte event it holds SCL low until software services the byte. Software does this by reading the received byte (`rd_ack`) or by supplying the next byte to send (`tx_wr`), so a slow CPU never loses a byte. The master sets the bus rate, standard or fast mode, and the engine never drives SCL high.

Top module: `i2c_slave_engine`

## Requirements
- R1: From reset the engine drives neither line. A STOP that ends a frame in which this slave was selected pulses `ev_stop` for one cycle, and both `sda_oe` and `scl_oe` are low from the cycle after the STOP is recognised.
- R2: With `cfg_mode10`=0, an address byte whose upper seven bits equal `cfg_addr[6:0]` is acknowledged: SDA is held low during the 9th clock. `ev_addr_match` pulses, and `is_tx` takes the byte's bit 0 (1 = master reads). Any other address gets no acknowledge and no event until the next START.
- R3: The address byte 0x00 is acknowledged, with `gc_hit`=1 and `is_tx`=0, only while `cfg_gc_en`=1. While `cfg_gc_en`=0 the byte is not acknowledged.
- R4: With `cfg_mode10`=1, a header byte `11110`,`cfg_addr[9:8]`,0 is acknowledged without an event. A second byte equal to `cfg_addr[7:0]` is then acknowledged and pulses `ev_addr_match` with `is_tx`=0. A second byte that does not match is not acknowledged.
- R5: A header byte with bit 0 = 1 is acknowledged, pulsing `ev_addr_match` with `is_tx`=1, only if a full 10-bit write address matched this slave since the last STOP. Otherwise the header is not acknowledged.
- R6: Each received data byte, most significant bit first, appears on `rx_data` together with a one-cycle `ev_byte_done`. This happens on the 8th rising SCL edge.
- R7: While `cfg_ack_en`=0, address bytes are not acknowledged and produce no event. A data byte received in an already open frame is still reported on `rx_data`, but it is not acknowledged.
- R8: After a received data byte, SCL is held low from the falling edge that opens the acknowledge clock until `rd_ack`. In a read, SCL is held low before each byte until `tx_wr`. Stretching ends within two cycles of the service pulse.
- R9: A byte loaded by `tx_wr` is sent most significant bit first. A master acknowledge pulses `ev_byte_done`. A not-acknowledge pulses `ev_ack_fail`, and SDA then stays released for the rest of the frame.
- R10: A `tx_wr` pulse given while no transmit slot is pending is ignored, and the next byte sent is the one written in the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (acknowledge or zero bit) |
| cfg_addr | input | 10 | Own address; bits 6:0 in 7-bit mode, all ten in 10-bit mode |
| cfg_mode10 | input | 1 | Select 10-bit addressing |
| cfg_gc_en | input | 1 | Answer the general-call address |
| cfg_ack_en | input | 1 | Allow acknowledge generation |
| rx_data | output | 8 | Last received data byte |
| rd_ack | input | 1 | Software has read the received byte |
| tx_data | input | 8 | Next byte to send |
| tx_wr | input | 1 | Software supplies `tx_data` |
| is_tx | output | 1 | Selected as transmitter |
| gc_hit | output | 1 | Selected through general call |
| ev_addr_match | output | 1 | Pulse: address matched |
| ev_byte_done | output | 1 | Pulse: data byte completed |
| ev_ack_fail | output | 1 | Pulse: master did not acknowledge |
| ev_stop | output | 1 | Pulse: STOP ending a selected frame |

## Verification
The bench keeps the default parameters: two synchroniser stages and a three-cycle glitch filter. These give a known latency of about six clocks from a line change to its recognition. The bench uses a bus quarter-bit of 25 clocks, so the master's data setup, the slave's acknowledge release and the stretch start all fall well inside the low phase of SCL. It can therefore check cycle-exact stretch release and the acknowledge level at the middle of each high phase. A scripted software model services each stretch after a deliberate delay. This makes the master's wait on a held SCL visible, along with repeated START in 10-bit reads and a mid-frame change of the acknowledge enable.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] HDR10_TAG = 5'b11110;
  localparam logic [7:0] GCALL_BYTE = 8'h00;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR2,
    ST_ACK_WAIT,
    ST_ACK_HOLD,
    ST_RX,
    ST_TLOAD,
    ST_TX,
    ST_TACK,
    ST_TNEXT,
    ST_WAIT
  } i2cs_state_e;
endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_cnt;
  logic                   sync_out;

  assign sync_out = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], din};
  end

  // output follows the synchronised line only after FILT_LEN steady cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= 1'b1;
      run_cnt <= '0;
    end else if (sync_out == dout) begin
      run_cnt <= '0;
    end else if (run_cnt == CW'(FILT_LEN - 1)) begin
      dout    <= sync_out;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R1: filtered level only ever moves toward the synchronised level
  p_filter_follow_r1: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> (dout == $past(sync_out)));
endmodule

// File: rtl/i2cs_bus_cond.sv
module i2cs_bus_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_f,
  output logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] filt_lines;
  logic              scl_q, sda_q;

  assign raw_lines = {sda_i, scl_i};

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    i2cs_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw_lines[i]),
      .dout(filt_lines[i])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

  // R1: bus conditions and clock edges never coincide
  p_cond_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_det, stop_det, scl_rise, scl_fall}));
endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic [9:0] cfg_addr,
  input  logic       cfg_mode10,
  input  logic       cfg_gc_en,
  input  logic       cfg_ack_en,
  output logic [7:0] rx_data,
  input  logic       rd_ack,
  input  logic [7:0] tx_data,
  input  logic       tx_wr,
  output logic       is_tx,
  output logic       gc_hit,
  output logic       ev_addr_match,
  output logic       ev_byte_done,
  output logic       ev_ack_fail,
  output logic       ev_stop
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic scl_f, sda_f, scl_rise, scl_fall, start_det, stop_det;

  i2cs_bus_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2cs_state_e        state, nxt;
  logic [CNT_W-1:0]   bit_cnt;
  logic [BYTE_W-2:0]  sh_in;
  logic [BYTE_W-2:0]  sh_out;
  logic [BYTE_W-1:0]  byte_in;
  logic               ack_this, is_data, rx_pend, matched10, selected;
  logic               hdr_ok, own7_hit, gc_ok;

  assign byte_in  = {sh_in, sda_f};
  assign hdr_ok   = (byte_in[7:3] == HDR10_TAG) && (byte_in[2:1] == cfg_addr[9:8]);
  assign own7_hit = !cfg_mode10 && (byte_in[7:1] == cfg_addr[6:0]);
  assign gc_ok    = cfg_gc_en && (byte_in == GCALL_BYTE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      nxt           <= ST_IDLE;
      bit_cnt       <= '0;
      sh_in         <= '0;
      sh_out        <= '0;
      ack_this      <= 1'b0;
      is_data       <= 1'b0;
      rx_pend       <= 1'b0;
      matched10     <= 1'b0;
      selected      <= 1'b0;
      sda_oe        <= 1'b0;
      scl_oe        <= 1'b0;
      rx_data       <= '0;
      is_tx         <= 1'b0;
      gc_hit        <= 1'b0;
      ev_addr_match <= 1'b0;
      ev_byte_done  <= 1'b0;
      ev_ack_fail   <= 1'b0;
      ev_stop       <= 1'b0;
    end else begin
      ev_addr_match <= 1'b0;
      ev_byte_done  <= 1'b0;
      ev_ack_fail   <= 1'b0;
      ev_stop       <= 1'b0;
      if (rd_ack) rx_pend <= 1'b0;

      if (stop_det) begin
        state     <= ST_IDLE;
        sda_oe    <= 1'b0;
        scl_oe    <= 1'b0;
        matched10 <= 1'b0;
        selected  <= 1'b0;
        ev_stop   <= selected;
      end else if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
        scl_oe  <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (scl_rise) begin
            sh_in   <= byte_in[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              is_data  <= 1'b0;
              ack_this <= 1'b1;
              state    <= ST_ACK_WAIT;
              if (!cfg_ack_en) begin
                state <= ST_WAIT;
              end else if (own7_hit) begin
                ev_addr_match <= 1'b1;
                selected      <= 1'b1;
                is_tx         <= byte_in[0];
                gc_hit        <= 1'b0;
                nxt           <= byte_in[0] ? ST_TLOAD : ST_RX;
              end else if (gc_ok) begin
                ev_addr_match <= 1'b1;
                selected      <= 1'b1;
                is_tx         <= 1'b0;
                gc_hit        <= 1'b1;
                nxt           <= ST_RX;
              end else if (cfg_mode10 && hdr_ok && !byte_in[0]) begin
                nxt <= ST_ADDR2;
              end else if (cfg_mode10 && hdr_ok && matched10) begin
                ev_addr_match <= 1'b1;
                selected      <= 1'b1;
                is_tx         <= 1'b1;
                gc_hit        <= 1'b0;
                nxt           <= ST_TLOAD;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          ST_ADDR2: if (scl_rise) begin
            sh_in   <= byte_in[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              if (cfg_ack_en && byte_in == cfg_addr[7:0]) begin
                matched10     <= 1'b1;
                selected      <= 1'b1;
                ev_addr_match <= 1'b1;
                is_tx         <= 1'b0;
                gc_hit        <= 1'b0;
                is_data       <= 1'b0;
                ack_this      <= 1'b1;
                nxt           <= ST_RX;
                state         <= ST_ACK_WAIT;
              end else begin
                matched10 <= 1'b0;
                state     <= ST_WAIT;
              end
            end
          end
          ST_RX: if (scl_rise) begin
            sh_in   <= byte_in[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              rx_data      <= byte_in;
              ev_byte_done <= 1'b1;
              rx_pend      <= 1'b1;
              is_data      <= 1'b1;
              ack_this     <= cfg_ack_en;
              nxt          <= ST_RX;
              state        <= ST_ACK_WAIT;
            end
          end
          ST_ACK_WAIT: if (scl_fall) begin
            sda_oe <= ack_this;
            scl_oe <= is_data && rx_pend && !rd_ack;
            state  <= ST_ACK_HOLD;
          end
          ST_ACK_HOLD: begin
            if (rd_ack) scl_oe <= 1'b0;
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              scl_oe  <= (nxt == ST_TLOAD);
              bit_cnt <= '0;
              state   <= nxt;
            end
          end
          ST_TLOAD: if (tx_wr) begin
            sh_out  <= tx_data[BYTE_W-2:0];
            sda_oe  <= ~tx_data[BYTE_W-1];
            scl_oe  <= 1'b0;
            bit_cnt <= '0;
            state   <= ST_TX;
          end
          ST_TX: if (scl_fall) begin
            if (bit_cnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              state  <= ST_TACK;
            end else begin
              sda_oe  <= ~sh_out[BYTE_W-2];
              sh_out  <= {sh_out[BYTE_W-3:0], 1'b0};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_TACK: if (scl_rise) begin
            if (sda_f) begin
              ev_ack_fail <= 1'b1;
              state       <= ST_WAIT;
            end else begin
              ev_byte_done <= 1'b1;
              state        <= ST_TNEXT;
            end
          end
          ST_TNEXT: if (scl_fall) begin
            scl_oe <= 1'b1;
            state  <= ST_TLOAD;
          end
          default: ;
        endcase
      end
    end
  end

  // R1: idle engine drives neither line
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (!sda_oe && !scl_oe));
  // R1: lines released right after a STOP
  p_stop_release_r1: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_oe && !scl_oe));
  // R8: SCL is held only in a service slot
  p_stretch_slot_r8: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> (state == ST_ACK_HOLD || state == ST_TLOAD));
  // R6: at most one event per cycle
  p_event_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_addr_match, ev_byte_done, ev_ack_fail, ev_stop}));
  // R9: a not-acknowledged transmitter stays off SDA
  p_nack_release_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> !sda_oe);
  // R8: a stretch never begins while SCL is seen high
  p_stretch_low_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe) |-> !scl_f);
endmodule

// File: tb/tb_i2c_slave_engine.sv
module tb_i2c_slave_engine;
  localparam int Q = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       m_scl_lo = 1'b0, m_sda_lo = 1'b0;
  logic       scl_bus, sda_bus, scl_oe, sda_oe;
  logic [9:0] cfg_addr = 10'h1A5;
  logic       cfg_mode10 = 1'b0, cfg_gc_en = 1'b0, cfg_ack_en = 1'b1;
  logic [7:0] rx_data, tx_data = 8'h00;
  logic       rd_ack = 1'b0, tx_wr = 1'b0;
  logic       is_tx, gc_hit, ev_addr_match, ev_byte_done, ev_ack_fail, ev_stop;

  assign scl_bus = !(m_scl_lo || scl_oe);
  assign sda_bus = !(m_sda_lo || sda_oe);

  i2c_slave_engine dut (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .cfg_addr(cfg_addr), .cfg_mode10(cfg_mode10), .cfg_gc_en(cfg_gc_en),
    .cfg_ack_en(cfg_ack_en), .rx_data(rx_data), .rd_ack(rd_ack),
    .tx_data(tx_data), .tx_wr(tx_wr), .is_tx(is_tx), .gc_hit(gc_hit),
    .ev_addr_match(ev_addr_match), .ev_byte_done(ev_byte_done),
    .ev_ack_fail(ev_ack_fail), .ev_stop(ev_stop)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard: kind 1 addr (val = {gc,is_tx}), 2 byte, 3 ack fail, 4 stop
  typedef struct packed {
    logic [2:0] kind;
    logic       chk;
    logic [7:0] val;
    logic [7:0] req;
  } exp_t;
  exp_t exp_q[$];
  logic [7:0] tx_q[$];

  task automatic push(input logic [2:0] k, input logic c, input logic [7:0] v, input logic [7:0] r);
    exp_q.push_back('{kind: k, chk: c, val: v, req: r});
  endtask

  exp_t mon_e;
  logic [2:0] mon_kind;
  always @(negedge clk) begin
    if (!rst && (ev_addr_match || ev_byte_done || ev_ack_fail || ev_stop)) begin
      mon_kind = ev_addr_match ? 3'd1 : ev_byte_done ? 3'd2 : ev_ack_fail ? 3'd3 : 3'd4;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected event", 32'(mon_kind), 32'd0);
      end else begin
        mon_e = exp_q.pop_front();
        check(mon_kind == mon_e.kind, $sformatf("R%0d", mon_e.req), "event kind",
              32'(mon_kind), 32'(mon_e.kind));
        if (mon_e.chk && mon_kind == 3'd1)
          check({gc_hit, is_tx} == mon_e.val[1:0], $sformatf("R%0d", mon_e.req),
                "gc/dir", 32'({gc_hit, is_tx}), 32'(mon_e.val[1:0]));
        if (mon_e.chk && mon_kind == 3'd2)
          check(rx_data == mon_e.val, $sformatf("R%0d", mon_e.req), "rx_data",
                32'(rx_data), 32'(mon_e.val));
      end
    end
  end

  // software model: services each stretch after a delay (R8)
  task automatic service(input bit tx);
    for (int i = 0; i < 400 && !scl_oe; i++) @(negedge clk);
    check(scl_oe == 1'b1, "R8", "stretch begins", 32'(scl_oe), 32'd1);
    repeat (20) @(negedge clk);
    check(scl_bus == 1'b0, "R8", "SCL still held", 32'(scl_bus), 32'd0);
    if (tx) begin
      tx_data = (tx_q.size() > 0) ? tx_q.pop_front() : 8'h00;
      tx_wr = 1'b1;
    end else begin
      rd_ack = 1'b1;
    end
    @(negedge clk);
    tx_wr = 1'b0;
    rd_ack = 1'b0;
    @(negedge clk);
    check(scl_oe == 1'b0, "R8", "stretch released", 32'(scl_oe), 32'd0);
  endtask

  initial begin : cpu
    forever begin
      @(negedge clk);
      if (!rst && ev_byte_done && !is_tx) service(1'b0);
      else if (!rst && is_tx && (ev_addr_match || ev_byte_done)) service(1'b1);
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wait_high();
    while (!scl_bus) @(negedge clk);
  endtask
  task automatic m_start();
    m_sda_lo = 1'b1; wq(Q); m_scl_lo = 1'b1; wq(Q);
  endtask
  task automatic m_rstart();
    m_sda_lo = 1'b0; wq(Q); m_scl_lo = 1'b0; wait_high(); wq(Q);
    m_sda_lo = 1'b1; wq(Q); m_scl_lo = 1'b1; wq(Q);
  endtask
  task automatic m_stop();
    m_sda_lo = 1'b1; wq(Q); m_scl_lo = 1'b0; wait_high(); wq(Q);
    m_sda_lo = 1'b0; wq(2 * Q);
  endtask
  task automatic m_bit_out(input logic b);
    m_sda_lo = !b; wq(Q); m_scl_lo = 1'b0; wait_high(); wq(2 * Q);
    m_scl_lo = 1'b1; wq(Q);
  endtask
  task automatic m_bit_in(output logic b);
    m_sda_lo = 1'b0; wq(Q); m_scl_lo = 1'b0; wait_high(); wq(Q);
    b = sda_bus; wq(Q); m_scl_lo = 1'b1; wq(Q);
  endtask
  task automatic m_wbyte(input logic [7:0] d, input bit exp_ack, input string req);
    logic a;
    for (int i = 7; i >= 0; i--) m_bit_out(d[i]);
    m_bit_in(a);
    check((!a) == exp_ack, req, $sformatf("ack after %02h", d), 32'(!a), 32'(exp_ack));
  endtask
  task automatic m_rbyte(input logic [7:0] exp_d, input bit give_ack, input string req);
    logic [7:0] d;
    for (int i = 7; i >= 0; i--) m_bit_in(d[i]);
    m_bit_out(!give_ack);
    check(d == exp_d, req, "read byte", 32'(d), 32'(exp_d));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    wq(10);
    rst = 1'b0;
    wq(2);
    check(!sda_oe && !scl_oe, "R1", "lines released after reset", 32'({sda_oe, scl_oe}), 32'd0);
    check({ev_addr_match, ev_byte_done, ev_ack_fail, ev_stop} == 4'b0, "R1", "no events after reset",
          32'({ev_addr_match, ev_byte_done, ev_ack_fail, ev_stop}), 32'd0);

    // R2 R6 R1: 7-bit write, own address 0x25 -> byte 0x4A
    m_start();
    push(3'd1, 1'b1, 8'h00, 8'd2);
    m_wbyte(8'h4A, 1'b1, "R2");
    push(3'd2, 1'b1, 8'h3C, 8'd6);
    m_wbyte(8'h3C, 1'b1, "R6");
    push(3'd2, 1'b1, 8'hA5, 8'd6);
    m_wbyte(8'hA5, 1'b1, "R6");
    push(3'd4, 1'b0, 8'h00, 8'd1);
    m_stop();
    wq(4);
    check(!sda_oe && !scl_oe, "R1", "released after STOP", 32'({sda_oe, scl_oe}), 32'd0);

    // R2: foreign address is ignored
    m_start();
    m_wbyte(8'h50, 1'b0, "R2");
    for (int i = 7; i >= 0; i--) m_bit_out(1'b1);
    m_stop();
    wq(4 * Q);

    // R3: general call off, then on
    m_start();
    m_wbyte(8'h00, 1'b0, "R3");
    m_stop();
    cfg_gc_en = 1'b1;
    m_start();
    push(3'd1, 1'b1, 8'h02, 8'd3);
    m_wbyte(8'h00, 1'b1, "R3");
    push(3'd2, 1'b1, 8'h11, 8'd6);
    m_wbyte(8'h11, 1'b1, "R6");
    push(3'd4, 1'b0, 8'h00, 8'd1);
    m_stop();
    cfg_gc_en = 1'b0;

    // R10: stray write while idle, then R9 read
    tx_data = 8'h99; tx_wr = 1'b1; wq(1); tx_wr = 1'b0; wq(Q);
    tx_q.push_back(8'hC3);
    tx_q.push_back(8'h5E);
    m_start();
    push(3'd1, 1'b1, 8'h01, 8'd2);
    m_wbyte(8'h4B, 1'b1, "R2");
    push(3'd2, 1'b0, 8'h00, 8'd9);
    m_rbyte(8'hC3, 1'b1, "R10");
    push(3'd3, 1'b0, 8'h00, 8'd9);
    m_rbyte(8'h5E, 1'b0, "R9");
    wq(2);
    check(sda_oe == 1'b0, "R9", "SDA released after NACK", 32'(sda_oe), 32'd0);
    push(3'd4, 1'b0, 8'h00, 8'd1);
    m_stop();

    // R7: acknowledge disabled mid-frame, then for an address
    m_start();
    push(3'd1, 1'b1, 8'h00, 8'd2);
    m_wbyte(8'h4A, 1'b1, "R2");
    cfg_ack_en = 1'b0;
    push(3'd2, 1'b1, 8'h77, 8'd7);
    m_wbyte(8'h77, 1'b0, "R7");
    push(3'd4, 1'b0, 8'h00, 8'd1);
    m_stop();
    m_start();
    m_wbyte(8'h4A, 1'b0, "R7");
    m_stop();
    cfg_ack_en = 1'b1;

    // R4 R5: 10-bit write then repeated-START read
    cfg_mode10 = 1'b1;
    tx_q.push_back(8'h81);
    m_start();
    m_wbyte(8'hF2, 1'b1, "R4");
    push(3'd1, 1'b1, 8'h00, 8'd4);
    m_wbyte(8'hA5, 1'b1, "R4");
    push(3'd2, 1'b1, 8'h6D, 8'd6);
    m_wbyte(8'h6D, 1'b1, "R6");
    m_rstart();
    push(3'd1, 1'b1, 8'h01, 8'd5);
    m_wbyte(8'hF3, 1'b1, "R5");
    push(3'd3, 1'b0, 8'h00, 8'd9);
    m_rbyte(8'h81, 1'b0, "R9");
    push(3'd4, 1'b0, 8'h00, 8'd1);
    m_stop();

    // R5: read header without a prior write match
    m_start();
    m_wbyte(8'hF3, 1'b0, "R5");
    m_stop();

    // R4: wrong low address byte
    m_start();
    m_wbyte(8'hF2, 1'b1, "R4");
    m_wbyte(8'hA4, 1'b0, "R4");
    m_stop();
    // R2: 7-bit address not answered in 10-bit mode
    m_start();
    m_wbyte(8'h4A, 1'b0, "R2");
    m_stop();

    wq(4 * Q);
    check(exp_q.size() == 0, "R6", "all expected events seen", 32'(exp_q.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule